// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses that the burst visits. A single-cycle start pulse captures a starting column, a burst length code and an ordering selector. On the following clock cycles the block emits one column address per cycle, with a valid flag, and raises a last flag on the final beat. The same length setting serves both read and write bursts, because the sequencer does not know which kind of burst it is serving.

The burst never leaves an aligned block of columns whose size equals the burst length. The column bits above that block size stay fixed at the values of the start column. Only the low bits move. In sequential order they count upward from the start position and wrap inside the block. In interleaved order they are the start position XORed with the beat index.

Control is a two-state machine. In `S_IDLE`, a start pulse latches the inputs and takes the transition *launch* to `S_RUN`. `S_RUN` holds on transition *advance* while the beat index is below the last one. On the final beat it takes transition *finish* back to `S_IDLE`. A start pulse seen in `S_RUN` takes no transition and is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after its release, with no start pulse, `col_valid` and `col_last` are 0.
- R2: A `start` pulse sampled while idle latches `start_col`, `len_sel` and `interleave`. Beat 0 appears in the next cycle, and its address equals the latched `start_col` exactly.
- R3: The burst lasts exactly L consecutive cycles with `col_valid` high. L is set by `len_sel`: 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. The reserved code 2'b00 is treated as 2.
- R4: `col_last` is high on the final beat of the burst and on no other beat.
- R5: On every beat, the column bits at and above position log2(L) equal those of the latched start column.
- R6: With `interleave` = 0, the low log2(L) bits of beat n are (start_low + n) mod L.
- R7: With `interleave` = 1, the low log2(L) bits of beat n are start_low XOR n.
- R8: A `start` pulse that arrives while a burst is active, including on its last beat, is ignored. The running burst's addresses, its length and its end do not change, and no extra beats follow.
- R9: After the last beat, `col_valid` is 0 for at least one cycle. A start pulse in that idle cycle begins a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request pulse |
| len_sel | input | 2 | Burst length code (01=2, 10=4, 11=8, 00 treated as 2) |
| interleave | input | 1 | Ordering: 0 sequential, 1 interleaved |
| start_col | input | COL_W | Starting column address |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | High on every beat of a burst |
| col_last | output | 1 | High on the final beat |

## Verification
The hardest case to reach is a start pulse that lands on a running burst, especially one that lands on the final beat, where the state machine is in the middle of its *finish* transition. The bench reaches it deliberately. While a burst is in progress, it raises `start` on the first beat and on the last beat, each time with a different random column, length and ordering. It then checks that every remaining address matches the original request and that the cycle after the last beat is idle. Directed bursts also place the start position at the top of the block and the top of the column space, so that wrapping inside the block is exercised.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Width of the in-block offset for the largest burst (8 beats)
    localparam int OFS_W = 3;

    typedef enum logic [1:0] {
        LEN_RSVD = 2'b00,
        LEN_2    = 2'b01,
        LEN_4    = 2'b10,
        LEN_8    = 2'b11
    } len_code_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

    // Offset mask (L-1) for a length code; the reserved code behaves as length 2
    function automatic logic [OFS_W-1:0] len_mask(input logic [1:0] code);
        logic [OFS_W-1:0] m;
        unique case (code)
            LEN_4:   m = 3'b011;
            LEN_8:   m = 3'b111;
            default: m = 3'b001;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       len_sel,
    input  logic             interleave,
    input  logic [COL_W-1:0] start_col,
    output logic             running,
    output logic             last_beat,
    output logic [OFS_W-1:0] beat,
    output logic [OFS_W-1:0] lat_mask,
    output logic             lat_il,
    output logic [COL_W-1:0] lat_col
);

    seq_state_e state_q, state_d;
    logic [OFS_W-1:0] beat_q;
    logic             at_end;

    assign at_end = (beat_q == lat_mask);

    // Next-state logic: launch, advance, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)  state_d = S_RUN;
            S_RUN:  if (at_end) state_d = S_IDLE;
            default:            state_d = S_IDLE;
        endcase
    end

    // State register, request capture and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            beat_q   <= '0;
            lat_mask <= 3'b001;
            lat_il   <= 1'b0;
            lat_col  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                lat_col  <= start_col;
                lat_mask <= len_mask(len_sel);
                lat_il   <= interleave;
                beat_q   <= '0;
            end else if (state_q == S_RUN) begin
                beat_q <= at_end ? '0 : beat_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        running   = (state_q == S_RUN);
        last_beat = (state_q == S_RUN) && at_end;
        beat      = beat_q;
    end

    // R2: a start pulse seen while idle opens a burst at beat 0
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && start) |=> (running && beat == '0));

    // R8: the captured request stays put for the whole burst
    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !last_beat) |=> ($stable(lat_col) && $stable(lat_mask) && $stable(lat_il)));

    // R3: the beat index stays below the burst length
    a_r3_beat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((beat & ~lat_mask) == '0));

    // R9: one idle cycle follows the final beat
    a_r9_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !running);

endmodule

// File: rtl/bseq_order.sv
module bseq_order
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [OFS_W-1:0] mask,
    input  logic             il,
    input  logic [OFS_W-1:0] beat,
    output logic [COL_W-1:0] col
);

    logic [OFS_W-1:0] start_low;
    logic [OFS_W-1:0] seq_low;
    logic [OFS_W-1:0] xor_low;
    logic [OFS_W-1:0] ofs;

    assign start_low = base_col[OFS_W-1:0];
    assign seq_low   = start_low + beat;   // wraps modulo 8, masked below
    assign xor_low   = start_low ^ beat;
    assign ofs       = il ? xor_low : seq_low;

    // Low bits: offset inside the block where the mask allows, else the base bit
    for (genvar i = 0; i < OFS_W; i++) begin : g_low
        assign col[i] = mask[i] ? ofs[i] : base_col[i];
    end

    // Upper bits always come from the base column
    for (genvar j = OFS_W; j < COL_W; j++) begin : g_high
        assign col[j] = base_col[j];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       len_sel,
    input  logic             interleave,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);

    localparam int HI_W = COL_W - OFS_W;

    logic             running;
    logic             last_beat;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] lat_mask;
    logic             lat_il;
    logic [COL_W-1:0] lat_col;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] keep_mask;

    bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_sel   (len_sel),
        .interleave(interleave),
        .start_col (start_col),
        .running   (running),
        .last_beat (last_beat),
        .beat      (beat),
        .lat_mask  (lat_mask),
        .lat_il    (lat_il),
        .lat_col   (lat_col)
    );

    bseq_order #(.COL_W(COL_W)) u_order (
        .base_col(lat_col),
        .mask    (lat_mask),
        .il      (lat_il),
        .beat    (beat),
        .col     (seq_col)
    );

    assign col_out   = running ? seq_col : '0;
    assign col_valid = running;
    assign col_last  = last_beat;
    assign keep_mask = ~{{HI_W{1'b0}}, lat_mask};

    // R5: block-select bits do not move between beats of one burst
    a_r5_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last) |=> ((col_out & keep_mask) == ($past(col_out) & keep_mask)));

    // R4: last only ever appears together with valid
    a_r4_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    // R1: nothing is presented while in reset
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> (!col_valid && !col_last));

endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;

    localparam int COL_W      = 11;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [1:0]       len_sel;
    logic             interleave;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;

    int checks = 0;
    int errors = 0;

    burst_col_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
        .interleave(interleave), .start_col(start_col),
        .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int beats_of(input logic [1:0] code);
        return (code == 2'b11) ? 8 : (code == 2'b10) ? 4 : 2;
    endfunction

    function automatic logic [COL_W-1:0] model_col(input logic [COL_W-1:0] c,
                                                  input logic [1:0] code,
                                                  input logic il, input int n);
        int L = beats_of(code);
        int lo = c % L;
        int ofs = il ? (lo ^ n) : ((lo + n) % L);
        return COL_W'((c - lo) + ofs);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One burst; optionally fires a stray start on the first and last beats
    task automatic run_burst(input logic [1:0] code, input logic il,
                             input logic [COL_W-1:0] c, input bit stray);
        int L = beats_of(code);
        @(negedge clk);
        start = 1'b1; len_sel = code; interleave = il; start_col = c;
        @(negedge clk);
        for (int n = 0; n < L; n++) begin
            check(n == 0 ? "R2 beat0" : (il ? "R7 interleaved" : "R6 sequential"),
                  32'(col_out), 32'(model_col(c, code, il, n)));
            check("R3 valid", 32'(col_valid), 32'd1);
            check("R4 last", 32'(col_last), 32'(n == L - 1));
            if (stray && (n == 0 || n == L - 1)) begin
                start      = 1'b1;   // R8: must be ignored
                len_sel    = 2'($urandom);
                interleave = 1'($urandom);
                start_col  = COL_W'($urandom);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R8/R9 idle after last", 32'(col_valid), 32'd0);
        check("R3 no extra last", 32'(col_last), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; len_sel = 2'b01; interleave = 1'b0; start_col = '0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(col_valid), 32'd0);
        check("R1 last in reset", 32'(col_last), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", 32'(col_valid), 32'd0);

        // Directed: every length and order, start at top of block and of column space
        for (int t = 0; t < 2; t++) begin
            for (int k = 1; k < 4; k++) begin
                run_burst(2'(k), 1'(t), 11'h7FF, 1'b0);            // R5 R6 R7 wrap
                run_burst(2'(k), 1'(t), 11'h2A5, 1'b0);
            end
        end
        run_burst(2'b00, 1'b0, 11'h013, 1'b0);                      // R3 reserved code
        run_burst(2'b00, 1'b1, 11'h013, 1'b0);
        run_burst(2'b11, 1'b0, 11'h006, 1'b1);                      // R8 stray starts
        run_burst(2'b01, 1'b1, 11'h3C1, 1'b1);

        // Random bursts, some with stray starts
        for (int r = 0; r < 60; r++) begin
            run_burst(2'($urandom), 1'($urandom), COL_W'($urandom), 1'($urandom));
        end
        finish_up();
    end

endmodule